// File: doc/BRIEF.md
# Synchrocheck Busbar Selection and Gating Controller

This block sits in front of a synchrocheck measuring engine. It handles the control around the engine; the voltage, phase and frequency comparisons stay inside the engine. Two select lines choose which of two busbar voltage channels feeds the engine. When the select lines give no clear choice, the block keeps the channel it already has. Every change of channel restarts a re-initialisation window, counted in prescaler ticks. While that window runs, no measuring flag and no close permit can leave the block.

The fuse-failure blocking lines are combined through an OR gate, and which lines count depends on the channel in use. Any active blocking line clears all eight measuring flags and the close permit at once. The engine itself keeps running while blocked. Two release lines, combined through an OR gate, drive the engine run-enable. When both release lines go low, the flags drop at once. The close permit is held for a programmable number of ticks and then drops, unless a blocking line or a re-initialisation ends it earlier.

A configuration input selects between single-busbar operation and dual-busbar operation. Every output is registered, so it answers the inputs of the preceding clock cycle.

Top module: `synck_sel_gate`

## Requirements
- R1: In dual mode, sel_a=1 with sel_b=0 selects channel 1 (bus2_sel=0), and sel_a=0 with sel_b=1 selects channel 2 (bus2_sel=1). bus2_sel shows the choice one cycle later.
- R2: In dual mode, the select patterns 00 and 11 leave bus2_sel unchanged.
- R3: With dual_mode=0, bus2_sel is 0 whatever the select lines are, and all three blocking lines (bus 1, bus 2, line) count.
- R4: A change of bus2_sel loads reinit_len into the re-initialisation counter. The counter falls by one on each prescaler tick (one tick every TICK_DIV cycles). eng_reinit is high while the count is nonzero. Flags and close permit stay 0 throughout. A synchronous reset loads the counter in the same way.
- R5: In dual mode, channel 1 counts the blocking lines blk_bus1 and blk_line, and channel 2 counts blk_bus2 and blk_line. The blocking line of the other bus has no effect.
- R6: An active counted blocking line clears flags_out and close_permit on the next cycle.
- R7: eng_run equals rel_a OR rel_b, delayed by one cycle.
- R8: When both release lines are low, flags_out is 0 on the next cycle. close_permit keeps its value while a hold counter, loaded with hold_len on every released cycle, counts down once per tick. It drops on the cycle after the counter reaches zero.
- R9: close_permit rises only when all of these hold: the engine reports all_ok, a release line is high, no counted blocking line is active and no re-initialisation is running.
- R10: Synchronous active-high reset gives bus2_sel=0, flags_out=0, close_permit=0 and eng_run=0.
- R11: A counted blocking line that becomes active during the hold countdown clears close_permit on the next cycle.
- R12: While the gate is open, flags_out copies meas_flags with this bit order: 0 start, 1 amplitude ok, 2 phase ok, 3 frequency ok, 4 live bus, 5 live line, 6 dead bus, 7 dead line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = two busbar channels, 0 = one |
| sel_a | input | 1 | Channel 1 select |
| sel_b | input | 1 | Channel 2 select |
| blk_bus1 | input | 1 | Fuse-failure block, bus 1 |
| blk_bus2 | input | 1 | Fuse-failure block, bus 2 |
| blk_line | input | 1 | Fuse-failure block, line |
| rel_a | input | 1 | Release line A |
| rel_b | input | 1 | Release line B |
| reinit_len | input | CNT_W | Re-initialisation length in ticks |
| hold_len | input | CNT_W | Permit hold delay in ticks |
| meas_flags | input | NFLAG | Engine measuring flags |
| all_ok | input | 1 | Engine reports all checks satisfied |
| bus2_sel | output | 1 | Selected channel (1 = channel 2) |
| eng_run | output | 1 | Engine run-enable |
| eng_reinit | output | 1 | Re-initialisation in progress |
| flags_out | output | NFLAG | Gated measuring flags |
| close_permit | output | 1 | Close permit |

## Verification
The hardest case to reach is a blocking line that arrives while the close permit is being held after release loss. Reaching it takes a completed re-initialisation, a granted permit and a release drop, followed within a few ticks by a block on a counted line. Directed sequences build that chain on purpose, once with the bus blocking line and once by waiting out the whole hold. Random phases with slowly changing release and select states then reach it again on varying tick phases, and a cycle-accurate bench model checks every output.

// File: rtl/synck_pkg.sv
package synck_pkg;
    // Bit positions of the measuring flag vector.
    localparam int FL_START  = 0;
    localparam int FL_AMPL   = 1;
    localparam int FL_PHASE  = 2;
    localparam int FL_FREQ   = 3;
    localparam int FL_LVBUS  = 4;
    localparam int FL_LVLINE = 5;
    localparam int FL_DDBUS  = 6;
    localparam int FL_DDLINE = 7;

    typedef enum logic [1:0] {
        SEL_KEEP = 2'd0,
        SEL_CH1  = 2'd1,
        SEL_CH2  = 2'd2
    } sel_cmd_e;
endpackage

// File: rtl/synck_prescaler.sv
module synck_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/synck_bus_select.sv
module synck_bus_select
    import synck_pkg::*;
(
    input  logic dual_mode,
    input  logic sel_a,
    input  logic sel_b,
    input  logic cur_bus2,
    input  logic blk_bus1,
    input  logic blk_bus2,
    input  logic blk_line,
    output logic nxt_bus2,
    output logic switch_evt,
    output logic blocked
);
    sel_cmd_e cmd;

    always_comb begin
        unique case ({sel_a, sel_b})
            2'b10:   cmd = SEL_CH1;
            2'b01:   cmd = SEL_CH2;
            default: cmd = SEL_KEEP;
        endcase

        if (!dual_mode)          nxt_bus2 = 1'b0;
        else if (cmd == SEL_CH1) nxt_bus2 = 1'b0;
        else if (cmd == SEL_CH2) nxt_bus2 = 1'b1;
        else                     nxt_bus2 = cur_bus2;

        switch_evt = (nxt_bus2 != cur_bus2);

        if (!dual_mode) blocked = blk_bus1 | blk_bus2 | blk_line;
        else if (nxt_bus2) blocked = blk_bus2 | blk_line;
        else               blocked = blk_bus1 | blk_line;
    end
endmodule

// File: rtl/synck_reinit_timer.sv
module synck_reinit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy_nxt,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)                     cnt_d = len;
        else if (tick && cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else                          cnt_d = cnt_q;
        busy_nxt = (cnt_d != '0);
        busy     = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= len;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/synck_sel_gate.sv
module synck_sel_gate #(
    parameter int CNT_W    = 16,
    parameter int NFLAG    = 8,
    parameter int TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dual_mode,
    input  logic             sel_a,
    input  logic             sel_b,
    input  logic             blk_bus1,
    input  logic             blk_bus2,
    input  logic             blk_line,
    input  logic             rel_a,
    input  logic             rel_b,
    input  logic [CNT_W-1:0] reinit_len,
    input  logic [CNT_W-1:0] hold_len,
    input  logic [NFLAG-1:0] meas_flags,
    input  logic             all_ok,
    output logic             bus2_sel,
    output logic             eng_run,
    output logic             eng_reinit,
    output logic [NFLAG-1:0] flags_out,
    output logic             close_permit
);
    typedef struct packed {
        logic             bus2;
        logic             run;
        logic [NFLAG-1:0] flags;
        logic             permit;
        logic [CNT_W-1:0] hold;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic tick, nxt_bus2, switch_evt, blocked, busy_nxt, busy;
    logic released;

    synck_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    synck_bus_select u_sel (
        .dual_mode (dual_mode),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .cur_bus2  (st_q.bus2),
        .blk_bus1  (blk_bus1),
        .blk_bus2  (blk_bus2),
        .blk_line  (blk_line),
        .nxt_bus2  (nxt_bus2),
        .switch_evt(switch_evt),
        .blocked   (blocked)
    );

    synck_reinit_timer #(.CNT_W(CNT_W)) u_reinit (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .load    (switch_evt),
        .len     (reinit_len),
        .busy_nxt(busy_nxt),
        .busy    (busy)
    );

    always_comb begin
        released   = rel_a | rel_b;
        st_d       = st_q;
        st_d.bus2  = nxt_bus2;
        st_d.run   = released;
        st_d.flags = (released && !blocked && !busy_nxt) ? meas_flags : '0;

        if (blocked || busy_nxt) begin
            st_d.permit = 1'b0;
            st_d.hold   = '0;
        end else if (released) begin
            st_d.permit = all_ok;
            st_d.hold   = hold_len;
        end else if (st_q.hold == '0) begin
            st_d.permit = 1'b0;
        end else if (tick) begin
            st_d.hold = st_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign bus2_sel     = st_q.bus2;
    assign eng_run      = st_q.run;
    assign eng_reinit   = busy;
    assign flags_out    = st_q.flags;
    assign close_permit = st_q.permit;
endmodule

// File: rtl/synck_sel_gate_chk.sv
module synck_sel_gate_chk #(
    parameter int CNT_W = 16,
    parameter int NFLAG = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             dual_mode,
    input logic             sel_a,
    input logic             sel_b,
    input logic             blk_line,
    input logic             eng_run,
    input logic             eng_reinit,
    input logic             bus2_sel,
    input logic [NFLAG-1:0] flags_out,
    input logic             close_permit
);
    p_ambig_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (dual_mode && (sel_a == sel_b)) |=> $stable(bus2_sel));

    p_single_ch1_r3: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |=> !bus2_sel);

    p_reinit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        eng_reinit |-> (flags_out == '0 && !close_permit));

    p_line_block_r6: assert property (@(posedge clk) disable iff (rst)
        blk_line |=> (flags_out == '0 && !close_permit));

    p_flags_need_run_r8: assert property (@(posedge clk) disable iff (rst)
        (flags_out != '0) |-> eng_run);

    p_permit_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(close_permit) |-> (eng_run && !eng_reinit));
endmodule

bind synck_sel_gate synck_sel_gate_chk #(.CNT_W(CNT_W), .NFLAG(NFLAG)) u_chk (.*);

// File: tb/sim_synck_sel_gate.sv
module sim_synck_sel_gate;
    localparam int CW  = 8;
    localparam int NF  = 8;
    localparam int DIV = 4;
    localparam logic [CW-1:0] RLEN = 8'd5;
    localparam logic [CW-1:0] HLEN = 8'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dual_mode = 1'b1, sel_a = 1'b1, sel_b = 1'b0;
    logic blk_bus1 = 1'b0, blk_bus2 = 1'b0, blk_line = 1'b0;
    logic rel_a = 1'b0, rel_b = 1'b0, all_ok = 1'b1;
    logic [CW-1:0] reinit_len = RLEN, hold_len = HLEN;
    logic [NF-1:0] meas_flags = 8'hA5;
    logic bus2_sel, eng_run, eng_reinit, close_permit;
    logic [NF-1:0] flags_out;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    synck_sel_gate #(.CNT_W(CW), .NFLAG(NF), .TICK_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .dual_mode(dual_mode), .sel_a(sel_a), .sel_b(sel_b),
        .blk_bus1(blk_bus1), .blk_bus2(blk_bus2), .blk_line(blk_line),
        .rel_a(rel_a), .rel_b(rel_b), .reinit_len(reinit_len), .hold_len(hold_len),
        .meas_flags(meas_flags), .all_ok(all_ok), .bus2_sel(bus2_sel),
        .eng_run(eng_run), .eng_reinit(eng_reinit), .flags_out(flags_out),
        .close_permit(close_permit)
    );

    function automatic logic f_sel(input logic dual, input logic a, input logic b,
                                   input logic cur);
        if (!dual) return 1'b0;
        if (a && !b) return 1'b0;
        if (!a && b) return 1'b1;
        return cur;
    endfunction

    function automatic logic f_blk(input logic dual, input logic ch2, input logic b1,
                                   input logic b2, input logic bl);
        if (!dual) return b1 | b2 | bl;
        return ch2 ? (b2 | bl) : (b1 | bl);
    endfunction

    // Reference model, cycle by cycle from the requirements.
    int m_pre = 0;
    logic m_bus2 = 1'b0, m_run = 1'b0, m_permit = 1'b0;
    logic [CW-1:0] m_rcnt = '0, m_hold = '0;
    logic [NF-1:0] m_flags = '0;

    always @(posedge clk) begin : model
        logic tk, nb2, bl, busy, rel;
        logic [CW-1:0] nr;
        if (rst) begin
            m_pre = 0; m_bus2 = 1'b0; m_rcnt = reinit_len; m_hold = '0;
            m_permit = 1'b0; m_flags = '0; m_run = 1'b0;
        end else begin
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            nb2 = f_sel(dual_mode, sel_a, sel_b, m_bus2);
            if (nb2 != m_bus2) nr = reinit_len;
            else if (tk && m_rcnt != 0) nr = m_rcnt - 1;
            else nr = m_rcnt;
            busy = (nr != 0);
            bl = f_blk(dual_mode, nb2, blk_bus1, blk_bus2, blk_line);
            rel = rel_a | rel_b;
            m_flags = (rel && !bl && !busy) ? meas_flags : '0;
            m_run = rel;
            if (bl || busy) begin
                m_permit = 1'b0; m_hold = '0;
            end else if (rel) begin
                m_permit = all_ok; m_hold = hold_len;
            end else if (m_hold == 0) begin
                m_permit = 1'b0;
            end else if (tk) begin
                m_hold = m_hold - 1;
            end
            m_bus2 = nb2; m_rcnt = nr;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cmp_on) begin
                chk("R1 model bus2_sel", 32'(bus2_sel), 32'(m_bus2));
                chk("R7 model eng_run", 32'(eng_run), 32'(m_run));
                chk("R4 model eng_reinit", 32'(eng_reinit), 32'(m_rcnt != 0));
                chk("R12 model flags_out", 32'(flags_out), 32'(m_flags));
                chk("R9 model close_permit", 32'(close_permit), 32'(m_permit));
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        bit ron;
        void'($urandom(32'd1234));
        cyc(3);
        chk("R10 reset bus2_sel", 32'(bus2_sel), 0);
        chk("R10 reset flags", 32'(flags_out), 0);
        chk("R10 reset permit", 32'(close_permit), 0);
        chk("R10 reset run", 32'(eng_run), 0);
        rst = 1'b0; cmp_on = 1'b1;
        sel_a = 1'b0; sel_b = 1'b1;
        cyc();
        chk("R1 channel 2 chosen", 32'(bus2_sel), 1);
        chk("R4 reinit after switch", 32'(eng_reinit), 1);
        sel_a = 1'b1; sel_b = 1'b1; cyc(3);
        chk("R2 11 keeps channel", 32'(bus2_sel), 1);
        sel_a = 1'b0; sel_b = 1'b0; cyc(3);
        chk("R2 00 keeps channel", 32'(bus2_sel), 1);
        cyc(30);
        rel_a = 1'b1; cyc(2);
        chk("R12 flags pass through", 32'(flags_out), 32'h A5);
        chk("R9 permit granted", 32'(close_permit), 1);
        blk_bus1 = 1'b1; cyc();
        chk("R5 other bus block ignored", 32'(flags_out), 32'hA5);
        blk_bus1 = 1'b0; blk_line = 1'b1; cyc();
        chk("R6 line block clears flags", 32'(flags_out), 0);
        chk("R6 line block clears permit", 32'(close_permit), 0);
        blk_line = 1'b0; cyc(2);
        rel_a = 1'b0; cyc();
        chk("R8 flags clear on release loss", 32'(flags_out), 0);
        cyc();
        chk("R8 permit held", 32'(close_permit), 1);
        blk_bus2 = 1'b1; cyc();
        chk("R11 block overrides hold", 32'(close_permit), 0);
        blk_bus2 = 1'b0; rel_a = 1'b1; cyc(2);
        rel_a = 1'b0; cyc(20);
        chk("R8 permit drops after hold", 32'(close_permit), 0);
        dual_mode = 1'b0; sel_a = 1'b0; sel_b = 1'b1; cyc();
        chk("R3 single mode forces channel 1", 32'(bus2_sel), 0);
        cyc(30);
        rel_b = 1'b1; blk_bus2 = 1'b1; cyc();
        chk("R3 all blocks count in single mode", 32'(flags_out), 0);
        blk_bus2 = 1'b0;
        dual_mode = 1'b1;
        ron = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            cyc();
            if ($urandom_range(199) == 0) dual_mode = ~dual_mode;
            if ($urandom_range(24) == 0) {sel_a, sel_b} = 2'($urandom_range(3));
            if ($urandom_range(39) == 0) ron = ~ron;
            rel_a = ron & ($urandom_range(1) == 1);
            rel_b = ron & ~rel_a;
            blk_bus1 = ($urandom_range(15) == 0);
            blk_bus2 = ($urandom_range(15) == 0);
            blk_line = ($urandom_range(23) == 0);
            all_ok = ($urandom_range(3) != 0);
            meas_flags = 8'($urandom);
        end
        cyc(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule